// File: doc/BRIEF.md
# Chained Two-Dimensional DMA Channel

This block is one DMA channel that copies 32-bit words between memory locations, driven by a linked list of descriptors that sit in the same memory it copies. A start pulse hands the channel the address of the first descriptor. The channel then repeats a fixed cycle for each descriptor: it reads the six descriptor words, moves the data it describes, raises its completion flags, and follows the link to the next descriptor. The chain stops on a zero link, or when the channel enable is low at a descriptor boundary.

A descriptor moves data in one of two ways. In linear mode it is one run of bytes. In two-dimensional mode it is a set of equal rows, and a signed stride is added to the source address and to the destination address between rows. Per-descriptor flags control whether each address advances after every word. Other flags drop the read, so zeros are written, or drop the write, so nothing is stored. All memory traffic uses one valid/ready request port and a read-response port, with at most one access in flight.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `busy`, `end_flag`, `irq`, `paused` and `mem_valid` are 0 and `live_len` is 0.
- R2: When idle, `start` loads `first_desc`, clears `end_flag`, `irq` and `paused`, and makes `busy` 1 on the next cycle. While the channel is busy, `start` has no effect. Each descriptor is fetched as six word reads at its base address plus 0, 4, 8, 12, 16 and 20. These words are, in that order: control flags, source address, destination address, length, stride and link.
- R3: Before each descriptor is fetched, the channel checks that `chan_en` is 1 and that the current descriptor address is nonzero. If either test fails, `busy` drops, `paused` is set, and no further memory request is made.
- R4: When control bit 1 is 0 (linear mode), the length word is the byte count and the descriptor moves length/4 words.
- R5: When control bit 1 is 1 (two-dimensional mode), the descriptor moves 1+length[29:16] rows of length[15:0] bytes. After every row except the last, the signed 16-bit stride[15:0] is added to the source address and the signed stride[31:16] is added to the destination address.
- R6: Control bit 8 adds 4 to the source address after each word, and control bit 4 does the same for the destination address. When a bit is clear, that address does not change within a row.
- R7: Control bit 11 suppresses the source read, and zero is written in its place. Control bit 7 suppresses the destination write.
- R8: At the end of every descriptor `end_flag` is set. If control bit 0 is also set, `irq` is set. Both flags stay set until the next accepted `start`.
- R9: After each moved word, `live_len` shows the bytes still to move in the current row. In two-dimensional mode the rows remaining, counting the current row, are placed in bits [31:16]. Before any word moves, it shows the fetched length word.
- R10: A row byte count that is zero or not a multiple of 4 moves no words, so the row completes at once with no data traffic.
- R11: Only one request is outstanding. A request holds its address, direction and data stable until `mem_ready` is 1, and the word written is the word read for the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain at `first_desc` |
| chan_en | input | 1 | Channel enable, sampled at descriptor boundaries |
| first_desc | input | AW | Byte address of the first descriptor |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Channel is processing a chain |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt from a descriptor with its interrupt bit set |
| paused | output | 1 | The chain has ended |
| live_len | output | 32 | Live remaining-length value |

## Verification
The bench runs every combination of the four increment and suppress flags in both modes. It uses negative and positive strides, and applies them to addresses that are held fixed as well as to addresses that advance. A stride applied after the last row, or a sign dropped from a stride, would leave data at the wrong place in memory. A suppressed read that still issues a request, or a suppressed write that still stores, shows up in the access counts and the memory image. Zero-length and unaligned rows catch a design that underflows the byte counter and runs away. Other cases cover a chain whose interrupt comes only from its middle descriptor, a mid-chain disable that must still finish the current descriptor, and a second start during a run. These catch flags that are overwritten, a disable that cuts a descriptor short, and a start that restarts the channel.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chan_en,
  input  logic [AW-1:0] first_desc,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          end_flag,
  output logic          irq,
  output logic          paused,
  output logic [31:0]   live_len
);
  localparam int DESC_WORDS = 6;
  localparam logic [2:0] LAST_W = 3'(DESC_WORDS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_SETUP, S_WORD, S_RREQ, S_RWAIT, S_WR
  } st_t;

  st_t           state;
  logic [2:0]    idx;
  logic [AW-1:0] ptr, nxt, src, dst;
  logic [31:0]   stride, data_q, bytes_left;
  logic [15:0]   xlen;
  logic [14:0]   rows_left;
  logic          f_int, f_2d, f_dinc, f_dign, f_sinc, f_sign;

  wire           word_ok  = (bytes_left != 32'd0) && (bytes_left[1:0] == 2'b00);
  wire [31:0]    nb       = bytes_left - 32'd4;
  wire [AW-1:0]  s_step   = {{(AW-16){stride[15]}}, stride[15:0]};
  wire [AW-1:0]  d_step   = {{(AW-16){stride[31]}}, stride[31:16]};
  wire [AW-1:0]  fetch_ad = ptr + {{(AW-5){1'b0}}, idx, 2'b00};

  assign busy      = (state != S_IDLE);
  assign mem_valid = (state == S_FREQ) || (state == S_RREQ) || (state == S_WR && !f_dign);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_FREQ) ? fetch_ad : (state == S_RREQ) ? src : dst;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;   idx <= '0;       ptr <= '0;     nxt <= '0;
      src <= '0;         dst <= '0;       stride <= '0;  data_q <= '0;
      bytes_left <= '0;  xlen <= '0;      rows_left <= '0;
      live_len <= '0;    end_flag <= 1'b0; irq <= 1'b0;  paused <= 1'b0;
      f_int <= 1'b0; f_2d <= 1'b0; f_dinc <= 1'b0; f_dign <= 1'b0;
      f_sinc <= 1'b0; f_sign <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr <= first_desc;
          end_flag <= 1'b0;
          irq <= 1'b0;
          paused <= 1'b0;
          state <= S_CHECK;
        end
        S_CHECK: if (chan_en && ptr != '0) begin
          idx <= '0;
          state <= S_FREQ;
        end else begin
          paused <= 1'b1;
          state <= S_IDLE;
        end
        S_FREQ: if (mem_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          case (idx)
            3'd0: begin
              f_int <= mem_rdata[0];  f_2d <= mem_rdata[1];   f_dinc <= mem_rdata[4];
              f_dign <= mem_rdata[7]; f_sinc <= mem_rdata[8]; f_sign <= mem_rdata[11];
            end
            3'd1: src <= mem_rdata[AW-1:0];
            3'd2: dst <= mem_rdata[AW-1:0];
            3'd3: live_len <= mem_rdata;
            3'd4: stride <= mem_rdata;
            default: nxt <= mem_rdata[AW-1:0];
          endcase
          if (idx == LAST_W) state <= S_SETUP;
          else begin
            idx <= idx + 3'd1;
            state <= S_FREQ;
          end
        end
        S_SETUP: begin
          if (f_2d) begin
            rows_left  <= 15'(live_len[29:16]) + 15'd1;
            xlen       <= live_len[15:0];
            bytes_left <= {16'd0, live_len[15:0]};
          end else begin
            rows_left  <= 15'd1;
            xlen       <= 16'd0;
            bytes_left <= live_len;
          end
          state <= S_WORD;
        end
        S_WORD: begin
          if (word_ok) begin
            if (f_sign) begin
              data_q <= 32'd0;
              state <= S_WR;
            end else state <= S_RREQ;
          end else if (rows_left > 15'd1) begin
            rows_left  <= rows_left - 15'd1;
            src        <= src + s_step;
            dst        <= dst + d_step;
            bytes_left <= {16'd0, xlen};
          end else begin
            end_flag <= 1'b1;
            if (f_int) irq <= 1'b1;
            ptr <= nxt;
            state <= S_CHECK;
          end
        end
        S_RREQ: if (mem_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (f_dign || mem_ready) begin
          if (f_sinc) src <= src + AW'(4);
          if (f_dinc) dst <= dst + AW'(4);
          bytes_left <= nb;
          live_len   <= f_2d ? {1'b0, rows_left, nb[15:0]} : nb;
          state <= S_WORD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R3
  AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !busy); // R3
  AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> end_flag); // R8
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !end_flag && !irq); // R2
  AST_NO_WRITE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(state) == S_WORD || $past(state) == S_RWAIT); // R11
endmodule

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;
  localparam int NW = 2048;
  localparam int DST_W0 = 1024;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, chan_en = 1'b1;
  logic [31:0] first_desc = '0;
  logic mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, live_len;
  logic busy, end_flag, irq, paused;

  logic [31:0] mem [0:NW-1];
  logic [31:0] expm [0:NW-1];
  logic rd_pend;
  logic [1:0] dly;
  logic [10:0] raddr;
  logic [15:0] lfsr;
  int rd_cnt, wr_cnt;
  logic bd_we = 1'b0, bd_clr = 1'b0;
  logic [10:0] bd_addr = '0;
  logic [31:0] bd_data = '0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chain_engine #(.AW(32)) u_dma_chain_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en), .first_desc(first_desc),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .end_flag(end_flag), .irq(irq), .paused(paused), .live_len(live_len));

  function automatic logic [31:0] patt(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= patt(i);
      rd_pend <= 1'b0; mem_rvalid <= 1'b0; mem_ready <= 1'b0; mem_rdata <= '0;
      lfsr <= 16'hACE1; rd_cnt <= 0; wr_cnt <= 0; dly <= '0; raddr <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready <= lfsr[0] | lfsr[5];
      mem_rvalid <= 1'b0;
      if (rd_pend) begin
        if (dly == 2'd0) begin
          mem_rvalid <= 1'b1;
          mem_rdata <= mem[raddr];
          rd_pend <= 1'b0;
        end else dly <= dly - 2'd1;
      end
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[12:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_pend <= 1'b1;
          raddr <= mem_addr[12:2];
          dly <= lfsr[2:1];
          rd_cnt <= rd_cnt + 1;
        end
      end
      if (bd_clr) begin
        for (int i = DST_W0; i < NW; i++) mem[i] <= FILL;
        rd_cnt <= 0;
        wr_cnt <= 0;
      end
      if (bd_we) mem[bd_addr] <= bd_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic bd_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a[12:2]; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
    expm[a[12:2]] = d;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] inf, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] ln, input logic [31:0] st,
                          input logic [31:0] nx);
    bd_wr(base, inf); bd_wr(base + 4, s); bd_wr(base + 8, d);
    bd_wr(base + 12, ln); bd_wr(base + 16, st); bd_wr(base + 20, nx);
  endtask

  task automatic clear_run;
    @(negedge clk); bd_clr = 1'b1;
    @(negedge clk); bd_clr = 1'b0;
    for (int i = DST_W0; i < NW; i++) expm[i] = FILL;
  endtask

  // Expected effect of one descriptor, from the length and stride arithmetic
  task automatic model(input logic [31:0] inf, input logic [31:0] s0, input logic [31:0] d0,
                       input logic [31:0] ln, input logic [31:0] st,
                       inout int erd, inout int ewr, output logic [31:0] elive);
    int rows, wpr;
    logic [31:0] xb, sa, da, v, sstep, dstep;
    bit sinc, dinc, sign, dign;
    sinc = inf[8]; dinc = inf[4]; sign = inf[11]; dign = inf[7];
    if (inf[1]) begin
      rows = 1 + int'(ln[29:16]); xb = {16'd0, ln[15:0]};
      sstep = {{16{st[15]}}, st[15:0]}; dstep = {{16{st[31]}}, st[31:16]};
    end else begin
      rows = 1; xb = ln; sstep = '0; dstep = '0;
    end
    wpr = (xb != 0 && xb[1:0] == 2'b00) ? int'(xb >> 2) : 0;
    for (int r = 0; r < rows; r++)
      for (int k = 0; k < wpr; k++) begin
        sa = s0 + 32'(r) * ((sinc ? 32'(4 * wpr) : 32'd0) + sstep) + (sinc ? 32'(4 * k) : 32'd0);
        da = d0 + 32'(r) * ((dinc ? 32'(4 * wpr) : 32'd0) + dstep) + (dinc ? 32'(4 * k) : 32'd0);
        v = sign ? 32'd0 : expm[sa[12:2]];
        if (!dign) expm[da[12:2]] = v;
      end
    erd += 6 + (sign ? 0 : rows * wpr);
    ewr += dign ? 0 : rows * wpr;
    if (wpr == 0) elive = ln;
    else elive = inf[1] ? 32'h0001_0000 : 32'd0;
  endtask

  task automatic go(input logic [31:0] fd, input bit restart, input bit drop_en);
    int n;
    @(negedge clk); first_desc = fd; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (busy && n < 20000) begin
      if (restart && rd_cnt >= 8) begin
        first_desc = 32'h80; start = 1'b1; restart = 1'b0;
      end else start = 1'b0;
      if (drop_en && wr_cnt >= 1) chan_en = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (n >= 20000) chk(1'b0, "R3 run did not stop", 32'(n), 32'd0);
  endtask

  task automatic chk_mem(input string tag);
    int mism; logic [31:0] fa, fe;
    mism = 0; fa = '0; fe = '0;
    for (int i = 0; i < NW; i++)
      if (mem[i] !== expm[i]) begin
        if (mism == 0) begin fa = mem[i]; fe = expm[i]; end
        mism++;
      end
    chk(mism == 0, tag, fa, fe);
  endtask

  initial begin
    int erd, ewr;
    logic [31:0] elive, inf, ln, st, d2;
    for (int i = 0; i < NW; i++) expm[i] = patt(i);
    repeat (4) @(negedge clk);
    chk(!busy && !end_flag && !irq && !paused && !mem_valid, "R1 reset flags",
        {27'd0, mem_valid, busy, end_flag, irq, paused}, 32'd0);
    chk(live_len == 32'd0, "R1 reset live_len", live_len, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep all flag combinations in both modes
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 16; f++) begin
        inf = (32'(f >> 2 & 1) << 11) | (32'(f & 1) << 8) | (32'(f >> 3 & 1) << 7) |
              (32'(f >> 1 & 1) << 4) | (32'(m) << 1) | 32'((f & 1) ^ (f >> 3 & 1));
        if (m == 0) begin
          ln = 32'(4 * (2 + f % 4)); st = 32'h1234_5678;
        end else begin
          ln = (32'(f % 3) << 16) | 32'(4 * (1 + f % 3));
          st = {(f % 3 == 0) ? 16'hFFFC : 16'd24, (f % 2 == 1) ? 16'hFFF8 : 16'd20};
        end
        clear_run;
        put_desc(32'h40, inf, 32'h0A00, 32'h1800, ln, st, 32'h0);
        erd = 0; ewr = 0;
        model(inf, 32'h0A00, 32'h1800, ln, st, erd, ewr, elive);
        go(32'h40, 1'b0, 1'b0);
        chk_mem(m ? "R5 R6 R7 2D memory image" : "R4 R6 R7 linear memory image");
        chk(rd_cnt == erd, "R7 R2 read count", 32'(rd_cnt), 32'(erd));
        chk(wr_cnt == ewr, "R7 write count", 32'(wr_cnt), 32'(ewr));
        chk(end_flag && irq == inf[0], "R8 end/irq", {30'd0, end_flag, irq}, {30'd0, 1'b1, inf[0]});
        chk(paused && !busy, "R3 paused at chain end", {30'd0, paused, busy}, 32'd2);
        chk(live_len == elive, "R9 live_len after run", live_len, elive);
      end

    // R10 unaligned linear length
    clear_run;
    put_desc(32'h40, 32'h0000_0111, 32'h0A00, 32'h1800, 32'd6, 32'h0, 32'h0);
    go(32'h40, 1'b0, 1'b0);
    chk(rd_cnt == 6 && wr_cnt == 0, "R10 unaligned no traffic", 32'(rd_cnt + wr_cnt), 32'd6);
    chk(live_len == 32'd6 && end_flag, "R10 live_len kept", live_len, 32'd6);

    // R10 zero-byte rows in 2D mode
    clear_run;
    put_desc(32'h40, 32'h0000_0113, 32'h0A00, 32'h1800, 32'h0002_0000, 32'h0010_0010, 32'h0);
    go(32'h40, 1'b0, 1'b0);
    chk(rd_cnt == 6 && wr_cnt == 0, "R10 zero rows no traffic", 32'(rd_cnt + wr_cnt), 32'd6);
    chk(live_len == 32'h0002_0000, "R9 R10 2D live_len kept", live_len, 32'h0002_0000);
    chk_mem("R10 memory untouched");

    // R2 R8 chain of three, interrupt only from the middle one
    clear_run;
    put_desc(32'h40, 32'h0000_0110, 32'h0A00, 32'h1800, 32'd16, 32'h0, 32'h80);
    put_desc(32'h80, 32'h0000_0113, 32'h0B00, 32'h1900, 32'h0001_0008, 32'h0008_0000, 32'hC0);
    put_desc(32'hC0, 32'h0000_0100, 32'h0C00, 32'h1A00, 32'd12, 32'h0, 32'h0);
    erd = 0; ewr = 0;
    model(32'h0000_0110, 32'h0A00, 32'h1800, 32'd16, 32'h0, erd, ewr, elive);
    model(32'h0000_0113, 32'h0B00, 32'h1900, 32'h0001_0008, 32'h0008_0000, erd, ewr, elive);
    model(32'h0000_0100, 32'h0C00, 32'h1A00, 32'd12, 32'h0, erd, ewr, elive);
    go(32'h40, 1'b0, 1'b0);
    chk_mem("R2 chain memory image");
    chk(rd_cnt == erd && wr_cnt == ewr, "R2 chain traffic", 32'(rd_cnt), 32'(erd));
    chk(irq && end_flag, "R8 irq held from middle descriptor", {31'd0, irq}, 32'd1);

    // R8 R3 start with zero pointer clears flags, no traffic
    clear_run;
    go(32'h0, 1'b0, 1'b0);
    chk(!irq && !end_flag, "R8 start clears flags", {30'd0, end_flag, irq}, 32'd0);
    chk(rd_cnt == 0 && paused, "R3 zero pointer ends chain", 32'(rd_cnt), 32'd0);

    // R3 enable low at start
    clear_run;
    chan_en = 1'b0;
    go(32'h40, 1'b0, 1'b0);
    chk(rd_cnt == 0 && paused && !end_flag, "R3 disabled channel idle", 32'(rd_cnt), 32'd0);
    chan_en = 1'b1;

    // R3 disable during first descriptor: it completes, the next is not fetched
    clear_run;
    put_desc(32'h40, 32'h0000_0110, 32'h0A00, 32'h1800, 32'd32, 32'h0, 32'h80);
    put_desc(32'h80, 32'h0000_0111, 32'h0B00, 32'h1A00, 32'd8, 32'h0, 32'h0);
    erd = 0; ewr = 0;
    model(32'h0000_0110, 32'h0A00, 32'h1800, 32'd32, 32'h0, erd, ewr, elive);
    go(32'h40, 1'b0, 1'b1);
    chan_en = 1'b1;
    chk(rd_cnt == erd && wr_cnt == ewr, "R3 stop at boundary", 32'(rd_cnt), 32'(erd));
    chk(end_flag && !irq && paused, "R3 first done only", {29'd0, end_flag, irq, paused}, 32'd5);
    chk_mem("R3 partial chain memory");

    // R2 start while busy ignored
    clear_run;
    d2 = 32'h0000_0110;
    put_desc(32'h40, d2, 32'h0A00, 32'h1800, 32'd24, 32'h0, 32'h0);
    put_desc(32'h80, 32'h0000_0111, 32'h0B00, 32'h1A00, 32'd8, 32'h0, 32'h0);
    erd = 0; ewr = 0;
    model(d2, 32'h0A00, 32'h1800, 32'd24, 32'h0, erd, ewr, elive);
    go(32'h40, 1'b1, 1'b0);
    chk(rd_cnt == erd && wr_cnt == ewr, "R2 start ignored while busy", 32'(rd_cnt), 32'(erd));
    chk(!irq, "R2 no second descriptor ran", {31'd0, irq}, 32'd0);
    chk_mem("R11 R2 memory after restart attempt");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R3 act=%0h exp=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule